// File: doc/BRIEF.md
# Three-Channel Serial Skew Aligner

The block takes three 1-bit sample streams that reach it with unknown relative delays and lines them up so that one sample index means the same instant on every channel. To learn the delays, all three inputs are fed the same pseudo-random training sequence. Channel 0 is the reference. For each of channels 1 and 2 the block counts, over a fixed window, how often that channel agrees with the reference seen through each candidate delay. The delay with the most agreements is taken as that channel's lag.

Once the lags are known, the block swallows bits on the channels that lead. The reference is held back by the largest lag. Each other channel is held back by the largest lag minus its own. Live samples then pass through these delays to a capture stage. A synchronous trigger opens a capture window in which all three channels are marked valid on the same cycles, for a programmable number of samples. Samples before the trigger are not marked.

Top module: `skew_aligner`

## Requirements
- R1: After reset, `aligned`, `align_error` and `cap_valid` are low and every channel delay is zero, so `cap_data[k]` equals `sample_in[k]` from one cycle earlier.
- R2: A `start_train` pulse while idle starts a run of 32 warm-up cycles, a 256-cycle counting window and a 32-cycle lag scan. The run ends with `aligned` or `align_error` high within 400 cycles of the pulse.
- R3: The lag of channel k (k = 1, 2) is the L in 0..31 for which `sample_in[k]` equals `sample_in[0]` delayed by L samples. It is found as the lag with the highest XNOR match count over the window.
- R4: When two or more lags give the same highest count, the smallest of those lags is chosen.
- R5: With M the larger of the two measured lags, channel 0 is delayed by M and channel k by M minus its lag. After `aligned`, all three bits of `cap_data` equal `sample_in[0]` from M+1 cycles earlier.
- R6: If either channel's best count is below 192 (75 percent of 256), the run ends with `align_error` high and `aligned` low.
- R7: `aligned` and `align_error` are never high together, and both are low from the cycle after a training run starts until it ends.
- R8: `trigger` is ignored while `aligned` is low and while a capture window is already open.
- R9: A trigger that is accepted makes `cap_valid` high from the next cycle for exactly `cap_len` cycles. A `cap_len` of 0 opens no window.
- R10: On the first valid cycle, `cap_data` holds the aligned samples of the cycle in which the trigger was high.
- R11: After a run that ends in `align_error`, the delays from the last successful run stay in force on `cap_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_train | input | 1 | Begins a training run when the block is idle |
| sample_in | input | 3 | One sample bit per channel; bit 0 is the reference |
| trigger | input | 1 | Synchronous capture trigger |
| cap_len | input | CAP_W (16) | Number of samples in a capture window |
| aligned | output | 1 | Last training run succeeded |
| align_error | output | 1 | Last training run found no lag with enough matches |
| cap_valid | output | 1 | Capture window is open for all three channels |
| cap_data | output | 3 | Aligned samples, one bit per channel |

## Verification
On every cycle the embedded properties check four things. The two status flags are never high together, and both stay low during a run. A capture window never opens without alignment and opens only after a trigger. The learned delays always give the reference the largest delay and leave one other channel with none. None of these properties shows that the measured lags are correct. The bench scenarios cover that by driving known delays, a periodic training pattern that forces a tie, and an uncorrelated channel, then comparing the delayed streams against its own model of the training sequence. The bench also checks the window length and the first captured sample.

// File: rtl/skew_pkg.sv
package skew_pkg;

    typedef enum logic [2:0] {
        TR_IDLE,
        TR_WARM,
        TR_ACC,
        TR_SCAN,
        TR_FIN
    } train_st_e;

endpackage

// File: rtl/skew_bit_delay.sv
module skew_bit_delay #(
    parameter int DEPTH = 32,
    localparam int SW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          din,
    input  logic [SW-1:0] sel,
    output logic          dout
);

    logic [DEPTH-2:0] sr_d, sr_q;
    logic [DEPTH-1:0] taps;

    always_comb begin
        taps = {sr_q, din};
        sr_d = taps[DEPTH-2:0];
        dout = taps[sel];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    AST_ONE_BIT_SWALLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && sel == SW'(1)) |-> dout == $past(din)); // R5

endmodule

// File: rtl/skew_lag_corr.sv
module skew_lag_corr #(
    parameter int LAGS = 32,
    parameter int CW   = 9,
    localparam int LW  = $clog2(LAGS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            acc_en,
    input  logic            scan_en,
    input  logic [LW-1:0]   scan_idx,
    input  logic [LAGS-1:0] ref_vec,
    input  logic            ch_bit,
    output logic [LW-1:0]   best_lag,
    output logic [CW-1:0]   best_cnt
);

    typedef struct packed {
        logic [LAGS-1:0][CW-1:0] cnt;
        logic [LW-1:0]           lag;
        logic [CW-1:0]           best;
    } corr_s;

    corr_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clear) begin
            s_d.cnt  = '0;
            s_d.lag  = '0;
            s_d.best = '0;
        end else begin
            if (acc_en) begin
                for (int l = 0; l < LAGS; l++) begin
                    s_d.cnt[l] = s_q.cnt[l] + CW'(ch_bit ~^ ref_vec[l]);
                end
            end
            // strict compare while scanning upward keeps the smaller lag on ties
            if (scan_en && (s_q.cnt[scan_idx] > s_q.best)) begin
                s_d.best = s_q.cnt[scan_idx];
                s_d.lag  = scan_idx;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign best_lag = s_q.lag;
    assign best_cnt = s_q.best;

    AST_BEST_NEVER_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |=> best_cnt >= $past(best_cnt)); // R4

endmodule

// File: rtl/skew_aligner.sv
module skew_aligner
    import skew_pkg::*;
#(
    parameter int MAX_LAG   = 32,
    parameter int WIN       = 256,
    parameter int CAP_W     = 16,
    parameter int MATCH_PCT = 75
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_train,
    input  logic [2:0]       sample_in,
    input  logic             trigger,
    input  logic [CAP_W-1:0] cap_len,
    output logic             aligned,
    output logic             align_error,
    output logic             cap_valid,
    output logic [2:0]       cap_data
);

    localparam int NCH = 3;
    localparam int LW  = $clog2(MAX_LAG);
    localparam int CW  = $clog2(WIN + 1);
    localparam int TW  = $clog2((WIN > MAX_LAG) ? WIN : MAX_LAG);
    localparam logic [CW-1:0] THRESH = CW'((WIN * MATCH_PCT + 99) / 100);

    typedef struct packed {
        train_st_e                st;
        logic [TW-1:0]            tmr;
        logic [MAX_LAG-2:0]       hist;
        logic [NCH-1:0][LW-1:0]   dly;
        logic                     ok;
        logic                     err;
        logic [CAP_W-1:0]         rem;
        logic [NCH-1:0]           data;
    } top_s;

    top_s s_d, s_q;

    logic [MAX_LAG-1:0]     ref_vec;
    logic                   corr_clear;
    logic [1:0][LW-1:0]     best_lag;
    logic [1:0][CW-1:0]     best_cnt;
    logic [NCH-1:0]         dly_out;
    logic [LW-1:0]          max_lag;

    assign ref_vec    = {s_q.hist, sample_in[0]};
    assign corr_clear = (s_q.st == TR_IDLE) && start_train;
    assign max_lag    = (best_lag[0] > best_lag[1]) ? best_lag[0] : best_lag[1];

    for (genvar g = 0; g < 2; g++) begin : g_corr
        skew_lag_corr #(.LAGS(MAX_LAG), .CW(CW)) i_corr (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear    (corr_clear),
            .acc_en   (s_q.st == TR_ACC),
            .scan_en  (s_q.st == TR_SCAN),
            .scan_idx (s_q.tmr[LW-1:0]),
            .ref_vec  (ref_vec),
            .ch_bit   (sample_in[g+1]),
            .best_lag (best_lag[g]),
            .best_cnt (best_cnt[g])
        );
    end

    for (genvar g = 0; g < NCH; g++) begin : g_dly
        skew_bit_delay #(.DEPTH(MAX_LAG)) i_dly (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (sample_in[g]),
            .sel   (s_q.dly[g]),
            .dout  (dly_out[g])
        );
    end

    always_comb begin
        s_d      = s_q;
        s_d.hist = ref_vec[MAX_LAG-2:0];
        s_d.data = dly_out;

        if (s_q.rem != '0)             s_d.rem = s_q.rem - CAP_W'(1);
        else if (trigger && s_q.ok)    s_d.rem = cap_len;

        unique case (s_q.st)
            TR_IDLE: begin
                if (start_train) begin
                    s_d.st  = TR_WARM;
                    s_d.tmr = '0;
                    s_d.ok  = 1'b0;
                    s_d.err = 1'b0;
                    s_d.rem = '0;
                end
            end
            TR_WARM: begin
                if (s_q.tmr == TW'(MAX_LAG - 1)) begin
                    s_d.st  = TR_ACC;
                    s_d.tmr = '0;
                end else s_d.tmr = s_q.tmr + TW'(1);
            end
            TR_ACC: begin
                if (s_q.tmr == TW'(WIN - 1)) begin
                    s_d.st  = TR_SCAN;
                    s_d.tmr = '0;
                end else s_d.tmr = s_q.tmr + TW'(1);
            end
            TR_SCAN: begin
                if (s_q.tmr == TW'(MAX_LAG - 1)) s_d.st = TR_FIN;
                else s_d.tmr = s_q.tmr + TW'(1);
            end
            TR_FIN: begin
                s_d.st = TR_IDLE;
                if (best_cnt[0] >= THRESH && best_cnt[1] >= THRESH) begin
                    s_d.ok     = 1'b1;
                    s_d.dly[0] = max_lag;
                    s_d.dly[1] = max_lag - best_lag[0];
                    s_d.dly[2] = max_lag - best_lag[1];
                end else begin
                    s_d.err = 1'b1;
                end
            end
            default: s_d.st = TR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign aligned     = s_q.ok;
    assign align_error = s_q.err;
    assign cap_valid   = (s_q.rem != '0);
    assign cap_data    = s_q.data;

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(aligned && align_error)); // R7
    AST_FLAGS_LOW_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st != TR_IDLE) |-> (!aligned && !align_error)); // R7
    AST_VALID_NEEDS_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |-> aligned); // R8
    AST_VALID_AFTER_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap_valid) |-> $past(trigger)); // R9
    AST_ZERO_LEN_NO_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (trigger && cap_len == '0 && !cap_valid) |=> !cap_valid); // R9
    AST_REF_DELAY_LARGEST: assert property (@(posedge clk) disable iff (!rst_n)
        aligned |-> (s_q.dly[0] >= s_q.dly[1] && s_q.dly[0] >= s_q.dly[2])); // R5
    AST_ONE_CH_UNDELAYED: assert property (@(posedge clk) disable iff (!rst_n)
        aligned |-> (s_q.dly[1] == '0 || s_q.dly[2] == '0)); // R5

endmodule

// File: tb/test_skew_aligner.sv
module test_skew_aligner;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_train = 1'b0;
    logic [2:0]  sample_in = '0;
    logic        trigger = 1'b0;
    logic [15:0] cap_len = '0;
    logic        aligned, align_error, cap_valid;
    logic [2:0]  cap_data;

    skew_aligner i_skew_aligner (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_train (start_train),
        .sample_in   (sample_in),
        .trigger     (trigger),
        .cap_len     (cap_len),
        .aligned     (aligned),
        .align_error (align_error),
        .cap_valid   (cap_valid),
        .cap_data    (cap_data)
    );

    always #2 clk = ~clk;

    // {lag1[4:0], lag2[4:0], channel 2 correlated}
    localparam logic [10:0] VECS [6] = '{
        {5'd5,  5'd17, 1'b1},
        {5'd31, 5'd3,  1'b1},
        {5'd0,  5'd0,  1'b1},
        {5'd12, 5'd12, 1'b1},
        {5'd12, 5'd7,  1'b0},
        {5'd0,  5'd31, 1'b1}
    };

    int          n_vec = 0, n_bad = 0, cycles = 0;
    logic [63:0] refh = '0;
    logic [14:0] prbs = 15'h4A3C;
    logic [8:0]  noise = 9'h1B5;
    int          l1 = 0, l2 = 0, m_exp = 0;
    bit          alt_mode = 1'b0, noise_mode = 1'b0;
    logic [2:0]  obs;
    logic        ovalid, exp_b;

    task automatic chk(bit ok, string req, string what, int act, int expv);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic tick();
        logic nb;
        @(negedge clk);
        obs    = cap_data;
        ovalid = cap_valid;
        exp_b  = refh[m_exp];
        prbs   = {prbs[13:0], prbs[14] ^ prbs[13]};
        noise  = {noise[7:0], noise[8] ^ noise[4]};
        nb     = alt_mode ? ~refh[0] : prbs[0];
        refh   = {refh[62:0], nb};
        sample_in = {noise_mode ? noise[0] : refh[l2], refh[l1], refh[0]};
        cycles++;
    endtask

    task automatic check_stream(int n, bit two_only, string req);
        int bad = 0;
        logic [2:0] a = '0;
        logic e = 1'b0;
        for (int i = 0; i < n; i++) begin
            tick();
            if (two_only ? (obs[1:0] != {2{exp_b}}) : (obs != {3{exp_b}})) begin
                if (bad == 0) begin a = obs; e = exp_b; end
                bad++;
            end
        end
        chk(bad == 0, req, "aligned stream", int'(a), e ? (two_only ? 3 : 7) : 0);
    endtask

    task automatic train(output int took);
        start_train = 1'b1;
        tick();
        start_train = 1'b0;
        // R7: flags cleared the cycle after the run starts
        chk(!aligned && !align_error, "R7", "flags low in run", {aligned, align_error}, 0);
        took = 0;
        while (!(aligned || align_error) && took < 400) begin
            tick();
            took++;
        end
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            if (cycles > 150000) begin
                n_bad++;
                $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
                $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
                $finish;
            end
        end
    end

    initial begin : main
        int took, vcount;
        for (int i = 0; i < 4; i++) tick();
        rst_n = 1'b1;
        tick();
        // R1: reset state
        chk(!aligned && !align_error && !cap_valid, "R1", "reset flags",
            {aligned, align_error, cap_valid}, 0);
        m_exp = 0;
        for (int i = 0; i < 4; i++) tick();
        check_stream(20, 1'b0, "R1");

        // R8: trigger before alignment has no effect
        cap_len = 16'd4;
        trigger = 1'b1;
        vcount = 0;
        for (int j = 0; j < 10; j++) begin
            tick();
            trigger = 1'b0;
            if (ovalid) vcount++;
        end
        chk(vcount == 0, "R8", "valid before alignment", vcount, 0);

        foreach (VECS[v]) begin
            l1 = int'(VECS[v][10:6]);
            l2 = int'(VECS[v][5:1]);
            noise_mode = !VECS[v][0];
            for (int i = 0; i < 40; i++) tick();
            train(took);
            chk(took < 400, "R2", "run completes", took, 330);
            if (VECS[v][0]) begin
                // R3 R5: measured lags give equal aligned streams
                chk(aligned && !align_error, "R3", "aligned flag", {aligned, align_error}, 2);
                m_exp = (l1 > l2) ? l1 : l2;
                check_stream(60, 1'b0, "R5");
            end else begin
                // R6: uncorrelated channel 2 -> error; R11: old delays kept
                chk(align_error && !aligned, "R6", "error flag", {aligned, align_error}, 1);
                check_stream(60, 1'b1, "R11");
            end
        end

        // R9 R10 R8: capture window of 5, retrigger mid-window ignored
        cap_len = 16'd5;
        trigger = 1'b1;
        vcount = 0;
        for (int j = 0; j < 12; j++) begin
            tick();
            if (j == 0) begin
                trigger = 1'b0;
                chk(ovalid && obs == {3{exp_b}}, "R10", "first captured sample",
                    {ovalid, obs}, {1'b1, {3{exp_b}}});
            end
            if (ovalid) vcount++;
            if (j == 2) trigger = 1'b1;
            if (j == 3) trigger = 1'b0;
        end
        chk(vcount == 5, "R9", "window length with retrigger (R8)", vcount, 5);

        // R9: zero length opens nothing
        cap_len = 16'd0;
        trigger = 1'b1;
        vcount = 0;
        for (int j = 0; j < 6; j++) begin
            tick();
            trigger = 1'b0;
            if (ovalid) vcount++;
        end
        chk(vcount == 0, "R9", "zero length window", vcount, 0);

        // R4: periodic training makes every even lag tie; smallest must win
        alt_mode = 1'b1;
        noise_mode = 1'b0;
        l1 = 2;
        l2 = 0;
        for (int i = 0; i < 40; i++) tick();
        train(took);
        chk(aligned, "R4", "tie run aligned", aligned, 1);
        alt_mode = 1'b0;
        l1 = 0;
        l2 = 0;
        m_exp = 0;
        check_stream(40, 1'b0, "R4");

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule